// File: doc/BRIEF.md
# Operating-Point Transition Sequencer

This block moves a processor from one operating point to another without ever clocking the logic faster than its present supply permits. A speed governor posts a target operating-point index. The block drives a voltage-select code to an external regulator and a clock-select code to a clock generator, and it orders the two updates according to the direction of the move.

To go faster, the block raises the supply first, counts a programmable number of settle cycles that stands in for the regulator ramp, and only then selects the faster clock. To go slower, it selects the slower clock first and lowers the supply on the following cycle. A configurable floor index caps how slow a request may go. A request that arrives during a transition waits in a one-entry holding slot. `busy` is high while a transition runs, and `done` pulses once when a transition finishes.

The index encoding is 0 = 5.0 V at full speed, 1 = 3.3 V at about 0.66, 2 = 2.2 V at about 0.44, and 3 = 1.0 V at about 0.2. A larger index always means a lower supply and a slower clock.

Top module: `dvfs_seq_top`

## Requirements
- R1: After synchronous reset, `volt_sel` and `clk_sel` are both 0 (full supply, full speed) and `busy` and `done` are both low.
- R2: On every cycle `clk_sel >= volt_sel`, so the selected clock is never faster than the selected supply allows.
- R3: Speed-up: `volt_sel` takes the target first. With S equal to the value of `settle_cycles` when the transition starts, `clk_sel` takes the target S+1 cycles later, in the same cycle that `done` pulses.
- R4: Slow-down: `clk_sel` takes the target first. `volt_sel` follows exactly one cycle later, in the same cycle that `done` pulses.
- R5: The effective target is min(`req_pt`, `floor_pt`). A request for an index above the floor settles at the floor index.
- R6: When the effective target equals the current point, `done` pulses without any change to `volt_sel` or `clk_sel`, and `busy` stays low.
- R7: A request made while `busy` is high is held and serviced after the running transition ends. The running transition still completes to its own target.
- R8: `done` is a single-cycle pulse with `busy` low. Whenever `busy` is low, `volt_sel == clk_sel`.
- R9: A request sampled at clock edge N makes its first output change, or its `done` pulse for R6, visible after edge N+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle |
| req_pt | input | IW | Requested operating-point index |
| floor_pt | input | IW | Slowest index allowed |
| settle_cycles | input | SETTLE_W | Regulator settle wait in cycles |
| volt_sel | output | IW | Supply select to the regulator |
| clk_sel | output | IW | Clock select to the clock generator |
| busy | output | 1 | Transition in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two functions can meet in one cycle. A new request can arrive while a speed-up is still counting settle cycles, and the holding slot's capture can coincide with the end of the running transition. The bench forces this by posting a slow-down in the middle of a long settle wait. It then checks three things: the first `done` still shows the first target, the held request starts on the edge after that `done`, and it completes in slow-down order. Randomized requests, floors and settle counts then exercise every direction and the clamp, with cycle-exact checks on the change times against a model in the bench.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE    = 2'd0,
        SQ_RAISE_V = 2'd1,
        SQ_LOWER_V = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        DIR_HOLD   = 2'd0,
        DIR_FASTER = 2'd1,
        DIR_SLOWER = 2'd2
    } move_dir_e;

    // Smaller index means higher supply and faster clock.
    function automatic move_dir_e pick_dir(input int unsigned target, input int unsigned cur);
        if (target == cur)     return DIR_HOLD;
        else if (target < cur) return DIR_FASTER;
        else                   return DIR_SLOWER;
    endfunction

    function automatic int unsigned clamp_pt(input int unsigned req, input int unsigned floor_idx);
        return (req > floor_idx) ? floor_idx : req;
    endfunction

endpackage

// File: rtl/dvfs_req_hold.sv
module dvfs_req_hold #(
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [IW-1:0] req_pt,
    input  logic          take,
    output logic          pend_v,
    output logic [IW-1:0] pend_pt
);
    // One-entry slot; a newer request overwrites an older one.
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_v  <= 1'b0;
            pend_pt <= '0;
        end else if (req_valid) begin
            pend_v  <= 1'b1;
            pend_pt <= req_pt;
        end else if (take) begin
            pend_v  <= 1'b0;
        end
    end
endmodule

// File: rtl/dvfs_settle_timer.sv
module dvfs_settle_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          run,
    output logic          expired
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                     cnt <= '0;
        else if (load)               cnt <= load_val;
        else if (run && cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/dvfs_seq_ctrl.sv
module dvfs_seq_ctrl
    import dvfs_pkg::*;
#(
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pend_v,
    input  logic [IW-1:0] pend_pt,
    input  logic [IW-1:0] floor_pt,
    input  logic          timer_expired,
    output logic          take,
    output logic          tmr_load,
    output logic          tmr_run,
    output logic [IW-1:0] volt_sel,
    output logic [IW-1:0] clk_sel,
    output logic          busy,
    output logic          done
);
    seq_state_e    state;
    logic [IW-1:0] goal;
    logic [IW-1:0] target;
    move_dir_e     dir;

    always_comb begin
        target = IW'(clamp_pt(int'(pend_pt), int'(floor_pt)));
        dir    = pick_dir(int'(target), int'(clk_sel));
    end

    assign take     = (state == SQ_IDLE) && pend_v;
    assign tmr_load = take && (dir == DIR_FASTER);
    assign tmr_run  = (state == SQ_RAISE_V);
    assign busy     = (state != SQ_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SQ_IDLE;
            volt_sel <= '0;
            clk_sel  <= '0;
            goal     <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                SQ_IDLE: begin
                    if (pend_v) begin
                        unique case (dir)
                            DIR_HOLD: done <= 1'b1;
                            DIR_FASTER: begin
                                volt_sel <= target;
                                goal     <= target;
                                state    <= SQ_RAISE_V;
                            end
                            default: begin
                                clk_sel <= target;
                                goal    <= target;
                                state   <= SQ_LOWER_V;
                            end
                        endcase
                    end
                end
                SQ_RAISE_V: begin
                    if (timer_expired) begin
                        clk_sel <= goal;
                        done    <= 1'b1;
                        state   <= SQ_IDLE;
                    end
                end
                default: begin
                    volt_sel <= goal;
                    done     <= 1'b1;
                    state    <= SQ_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/dvfs_seq_top.sv
module dvfs_seq_top #(
    parameter int NUM_PTS  = 4,
    parameter int SETTLE_W = 8,
    localparam int IW      = (NUM_PTS > 1) ? $clog2(NUM_PTS) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [IW-1:0]       req_pt,
    input  logic [IW-1:0]       floor_pt,
    input  logic [SETTLE_W-1:0] settle_cycles,
    output logic [IW-1:0]       volt_sel,
    output logic [IW-1:0]       clk_sel,
    output logic                busy,
    output logic                done
);
    logic          pend_v;
    logic [IW-1:0] pend_pt;
    logic          take;
    logic          tmr_load;
    logic          tmr_run;
    logic          tmr_expired;
    logic [IW-1:0] floor_eff;

    // A floor beyond the last defined point is treated as the last point.
    assign floor_eff = (int'(floor_pt) > NUM_PTS - 1) ? IW'(NUM_PTS - 1) : floor_pt;

    dvfs_req_hold #(.IW(IW)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_pt    (req_pt),
        .take      (take),
        .pend_v    (pend_v),
        .pend_pt   (pend_pt)
    );

    dvfs_settle_timer #(.CW(SETTLE_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (settle_cycles),
        .run      (tmr_run),
        .expired  (tmr_expired)
    );

    dvfs_seq_ctrl #(.IW(IW)) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .pend_v        (pend_v),
        .pend_pt       (pend_pt),
        .floor_pt      (floor_eff),
        .timer_expired (tmr_expired),
        .take          (take),
        .tmr_load      (tmr_load),
        .tmr_run       (tmr_run),
        .volt_sel      (volt_sel),
        .clk_sel       (clk_sel),
        .busy          (busy),
        .done          (done)
    );
endmodule

// File: rtl/dvfs_seq_checker.sv
module dvfs_seq_checker #(
    parameter int NUM_PTS  = 4,
    parameter int SETTLE_W = 8,
    localparam int IW      = (NUM_PTS > 1) ? $clog2(NUM_PTS) : 1
) (
    input logic                clk,
    input logic                rst,
    input logic [SETTLE_W-1:0] settle_cycles,
    input logic [IW-1:0]       volt_sel,
    input logic [IW-1:0]       clk_sel,
    input logic                busy,
    input logic                done
);
    logic [IW-1:0]       v_prev;
    logic [SETTLE_W:0]   gap;
    logic [SETTLE_W-1:0] snap;

    // Cycles since the supply select last moved, and the settle value at start.
    always_ff @(posedge clk) begin
        if (rst) begin
            v_prev <= '0;
            gap    <= '0;
            snap   <= '0;
        end else begin
            v_prev <= volt_sel;
            if (volt_sel != v_prev)  gap <= {{SETTLE_W{1'b0}}, 1'b1};
            else if (gap != '1)      gap <= gap + 1'b1;
            if (!busy)               snap <= settle_cycles;
        end
    end

    assert_clock_within_supply_R2: assert property (@(posedge clk) disable iff (rst)
        clk_sel >= volt_sel);

    assert_supply_settled_first_R3: assert property (@(posedge clk) disable iff (rst)
        (clk_sel < $past(clk_sel)) |-> ($stable(volt_sel) && volt_sel == clk_sel
                                        && gap == {1'b0, snap} + 1'b1));

    assert_clock_dropped_first_R4: assert property (@(posedge clk) disable iff (rst)
        (volt_sel > $past(volt_sel)) |-> ($stable(clk_sel) && $past(clk_sel) == volt_sel));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_idle_aligned_R8: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (volt_sel == clk_sel));
endmodule

bind dvfs_seq_top dvfs_seq_checker #(.NUM_PTS(NUM_PTS), .SETTLE_W(SETTLE_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .settle_cycles (settle_cycles),
    .volt_sel      (volt_sel),
    .clk_sel       (clk_sel),
    .busy          (busy),
    .done          (done)
);

// File: tb/test_dvfs_seq_top.sv
module test_dvfs_seq_top;
    localparam int NUM_PTS  = 4;
    localparam int SETTLE_W = 8;
    localparam int IW       = 2;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                req_valid = 1'b0;
    logic [IW-1:0]       req_pt = '0;
    logic [IW-1:0]       floor_pt = '1;
    logic [SETTLE_W-1:0] settle_cycles = '0;
    logic [IW-1:0]       volt_sel;
    logic [IW-1:0]       clk_sel;
    logic                busy;
    logic                done;

    int checks   = 0;
    int failures = 0;

    always #4 clk = ~clk;

    dvfs_seq_top #(.NUM_PTS(NUM_PTS), .SETTLE_W(SETTLE_W)) i_dvfs_seq_top (
        .clk (clk), .rst (rst), .req_valid (req_valid), .req_pt (req_pt),
        .floor_pt (floor_pt), .settle_cycles (settle_cycles),
        .volt_sel (volt_sel), .clk_sel (clk_sel), .busy (busy), .done (done)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int clamp_ref(input int r, input int f);
        return (r > f) ? f : r;
    endfunction

    // Request from idle; samples at negedges, index k = after k edges past the request edge.
    task automatic run_req(input int pt, input int flr, input int st);
        int v0, c0, tgt, v_at, c_at, d_at, order_bad, busy_seen;
        v0 = int'(volt_sel); c0 = int'(clk_sel);
        tgt = clamp_ref(pt, flr);
        v_at = -1; c_at = -1; d_at = -1; order_bad = 0; busy_seen = 0;
        req_valid = 1'b1; req_pt = IW'(pt); floor_pt = IW'(flr); settle_cycles = SETTLE_W'(st);
        for (int k = 1; k <= 40; k++) begin
            @(negedge clk);
            req_valid = 1'b0;
            if (int'(clk_sel) < int'(volt_sel)) order_bad++;
            if (busy) busy_seen++;
            if (v_at < 0 && int'(volt_sel) != v0) v_at = k;
            if (c_at < 0 && int'(clk_sel) != c0) c_at = k;
            if (d_at < 0 && done) begin
                d_at = k;
                check("R8 busy low at done", int'(busy), 0);
            end
        end
        check("R2 clock never above supply", order_bad, 0);
        check("R5 final supply is clamped target", int'(volt_sel), tgt);
        check("R5 final clock is clamped target", int'(clk_sel), tgt);
        check("R8 idle at end", int'(busy), 0);
        if (tgt == c0) begin
            check("R6 done on equal request", d_at, 2);
            check("R6 no supply change", v_at, -1);
            check("R6 no clock change", c_at, -1);
            check("R6 busy stays low", busy_seen, 0);
        end else if (tgt < c0) begin
            check("R9 supply moves first after one edge", v_at, 2);
            check("R3 clock follows after settle", c_at, 3 + st);
            check("R3 done with clock", d_at, 3 + st);
        end else begin
            check("R9 clock moves first after one edge", c_at, 2);
            check("R4 supply follows one cycle later", v_at, 3);
            check("R4 done with supply", d_at, 3);
        end
    endtask

    // Slow-down posted during a long speed-up settle wait.
    task automatic hold_test;
        int d1, d2, v1, c1, cs_at, vs_at, busy10;
        d1 = -1; d2 = -1; v1 = -1; c1 = -1; cs_at = -1; vs_at = -1; busy10 = 0;
        req_valid = 1'b1; req_pt = 2'd0; floor_pt = 2'd3; settle_cycles = 8'd6;
        for (int k = 1; k <= 30; k++) begin
            @(negedge clk);
            req_valid = 1'b0;
            if (done) begin
                if (d1 < 0) begin d1 = k; v1 = int'(volt_sel); c1 = int'(clk_sel); end
                else if (d2 < 0) d2 = k;
            end
            if (d1 > 0 && cs_at < 0 && clk_sel == 2'd3) cs_at = k;
            if (d1 > 0 && vs_at < 0 && volt_sel == 2'd3) vs_at = k;
            if (k == 10) busy10 = int'(busy);
            if (k == 3) begin req_valid = 1'b1; req_pt = 2'd3; end
        end
        check("R7 first transition completes", d1, 9);
        check("R7 first target supply", v1, 0);
        check("R7 first target clock", c1, 0);
        check("R7 held request clock drop", cs_at, 10);
        check("R7 held request supply drop", vs_at, 11);
        check("R7 busy during held service", busy10, 1);
        check("R7 second done", d2, 11);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h0D5E_0A11));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 supply at reset", int'(volt_sel), 0);
        check("R1 clock at reset", int'(clk_sel), 0);
        check("R1 busy at reset", int'(busy), 0);
        check("R1 done at reset", int'(done), 0);

        run_req(0, 3, 0);   // R6 equal at full speed
        run_req(2, 3, 0);   // R4 slow-down
        run_req(0, 3, 0);   // R3 speed-up with zero settle
        run_req(3, 1, 4);   // R5 clamp to floor 1
        run_req(3, 3, 0);   // R4 to slowest
        run_req(0, 3, 9);   // R3 long settle
        run_req(3, 3, 0);
        hold_test();        // R7

        for (int i = 0; i < 40; i++) begin
            int p, f, s;
            p = int'($urandom_range(3, 0));
            f = int'($urandom_range(3, 0));
            s = int'($urandom_range(9, 0));
            @(negedge clk);
            run_req(p, f, s);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule